// File: doc/BRIEF.md
# Serial Receiver with Break Detection

This block receives asynchronous serial characters in two frame shapes. The first is a short frame: a start bit, eight data bits and one stop bit. The second is a long frame: a start bit, eight data bits, a ninth bit and one stop bit. The line is sampled on a 16x oversampling tick that comes from outside the block. Each bit is decided by a vote of three samples around the middle of the bit. Data bits arrive least-significant first. The assembled character, its ninth bit and three sticky status flags are presented to the host logic. Each flag has its own single-cycle clear strobe.

A run of eleven consecutive low bit times is reported as a line break. In the short frame, that run covers the whole frame plus one further bit time after the stop bit. In the long frame, the frame itself is eleven bits. When break reset is enabled and the receiver is enabled, a detected break also produces a one-cycle reset-request pulse for a reset controller outside the block. After a break, the receiver ignores the line until it has returned high.

In long-frame mode, an address-filter enable lets a node ignore traffic that is not addressed to it. With the filter on, frames whose ninth bit is 0 never raise the receive flag.

Top module: `serial_rx_brk`

## Requirements
- R1: In short-frame mode (`nine_bit`=0), a frame is a low start bit, eight data bits sent LSB first, and a stop bit. After the stop bit is sampled, `rx_flag` rises, `rx_data` holds the eight data bits and `rx_bit9` holds the sampled stop bit.
- R2: In long-frame mode (`nine_bit`=1), the bit after the eight data bits is captured on `rx_bit9` and a single stop bit follows it.
- R3: Each bit value is the majority of the oversampling ticks numbered 7, 8 and 9, counting from tick 0 at which the low start edge was first seen. A start bit whose vote is high is dropped: no flag changes and the receiver resumes its search for a start edge.
- R4: `fe_flag` is set when the stop bit votes low. It stays set until `clr_fe` is pulsed.
- R5: In short-frame mode, a break is flagged when the start bit, all eight data bits, the stop bit and the next bit time all vote low. Ten low bit times followed by a high one do not flag a break.
- R6: In long-frame mode, a break is flagged when the start bit, all nine data bits and the stop bit vote low. Ten lows followed by a high stop bit do not flag a break.
- R7: `brk_flag` stays set until `clr_brk` is pulsed or the block is reset.
- R8: `rst_req` is a one-cycle high pulse issued with each detected break, but only while both `brk_reset_en` and `rx_en` are high.
- R9: In long-frame mode with `addr_filt_en`=1, a frame whose ninth bit is 0 leaves `rx_flag`, `rx_data` and `rx_bit9` unchanged. A frame whose ninth bit is 1 is accepted normally.
- R10: While `rx_flag` is set and not being cleared, later frames do not change `rx_data` or `rx_bit9`.
- R11: After a break, no start bit is searched for, and no frame or framing error can arise, until the line has been sampled high.
- R12: After reset, `rx_flag`, `fe_flag`, `brk_flag`, `rst_req`, `rx_data` and `rx_bit9` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Serial receive line, idles high |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects the long frame with a ninth bit |
| addr_filt_en | input | 1 | Drop long frames whose ninth bit is 0 |
| brk_reset_en | input | 1 | Allow a break to request a reset |
| clr_rxf | input | 1 | Clear strobe for rx_flag |
| clr_fe | input | 1 | Clear strobe for fe_flag |
| clr_brk | input | 1 | Clear strobe for brk_flag |
| rx_data | output | 8 | Received character |
| rx_bit9 | output | 1 | Ninth bit (long frame) or stop bit (short frame) |
| rx_flag | output | 1 | Sticky character-received flag |
| fe_flag | output | 1 | Sticky framing-error flag |
| brk_flag | output | 1 | Sticky break flag |
| rst_req | output | 1 | One-cycle reset-request pulse on break |

## Verification
The embedded properties assume that `nine_bit` and `addr_filt_en` only change while the line is idle between frames. They also assume that the clear strobes last a single cycle and that the enables do not toggle inside a frame. The bench changes modes and enables only during idle gaps of at least one bit time. It pulses each clear for exactly one cycle. It drives every bit for a whole number of bit times, aligned to the clock rather than to the tick phase, so the three-sample vote always falls inside a steady bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_EXTRA = 3'd4,
    ST_HOLD  = 3'd5
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic line,
  output logic vote
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [1:0]             hist_q, hist_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], rxd};
    hist_d = hist_q;
    if (tick) hist_d = {hist_q[0], line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign line = sync_q[SYNC_STAGES-1];
  // hist_q[1]/hist_q[0] hold the two previous tick samples, line the current one
  assign vote = maj3(hist_q[1], hist_q[0], line);

endmodule

// File: rtl/rx_lowrun.sv
module rx_lowrun #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  input  logic restart,
  output logic hit
);

  localparam int unsigned RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] FULL = RW'(RUN_LEN);

  logic [RW-1:0] run_q, run_d, run_inc;

  always_comb begin
    if (restart)            run_inc = RW'(1);
    else if (run_q == FULL) run_inc = FULL;
    else                    run_inc = run_q + RW'(1);
    run_d = run_q;
    if (bit_stb) run_d = bit_val ? '0 : run_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign hit = bit_stb && !bit_val && (run_inc == FULL) && (restart || run_q != FULL);

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= FULL);

  assert_high_clears_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && bit_val) |=> (run_q == '0));

endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              vote,
  input  logic              enable,
  input  logic              nine_bit,
  input  logic              brk_hit,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_b9,
  output logic              frame_stop,
  output logic              bit_stb,
  output logic              bit_val,
  output logic              run_restart
);

  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned SHR_W = DATA_W + 1;
  localparam int unsigned BN_W  = $clog2(SHR_W + 1);
  localparam logic [CNT_W-1:0] VOTE_AT = CNT_W'(OSR / 2 + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(OSR - 1);

  rx_state_t        state_q, state_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic [BN_W-1:0]  bitn_q, bitn_d;
  logic [SHR_W-1:0] shr_q, shr_d;
  logic             at_vote, at_end, in_frame;
  logic [BN_W-1:0]  last_bit;

  assign at_vote  = tick && (tcnt_q == VOTE_AT);
  assign at_end   = tick && (tcnt_q == LAST);
  assign in_frame = (state_q == ST_START) || (state_q == ST_DATA) ||
                    (state_q == ST_STOP)  || (state_q == ST_EXTRA);
  assign last_bit = nine_bit ? BN_W'(DATA_W) : BN_W'(DATA_W - 1);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bitn_d  = bitn_q;
    shr_d   = shr_q;
    if (tick && in_frame) tcnt_d = (tcnt_q == LAST) ? '0 : tcnt_q + CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        if (tick && !line) begin
          state_d = ST_START;
          tcnt_d  = CNT_W'(1);
        end
      end
      ST_START: begin
        if (at_vote && vote) state_d = ST_IDLE;
        else if (at_end) begin
          state_d = ST_DATA;
          bitn_d  = '0;
        end
      end
      ST_DATA: begin
        if (at_vote) shr_d = {vote, shr_q[SHR_W-1:1]};
        if (at_end) begin
          bitn_d = bitn_q + BN_W'(1);
          if (bitn_q == last_bit) state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (at_vote) begin
          if (brk_hit)                state_d = ST_HOLD;
          else if (vote || nine_bit)  state_d = ST_IDLE;
        end else if (at_end) begin
          state_d = ST_EXTRA;
        end
      end
      ST_EXTRA: begin
        if (at_vote) state_d = brk_hit ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: begin
        if (tick && line) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!enable) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bitn_q  <= '0;
      shr_q   <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bitn_q  <= bitn_d;
      shr_q   <= shr_d;
    end
  end

  assign frame_done  = (state_q == ST_STOP) && at_vote;
  assign frame_data  = nine_bit ? shr_q[DATA_W-1:0] : shr_q[SHR_W-1:1];
  assign frame_b9    = nine_bit ? shr_q[DATA_W] : vote;
  assign frame_stop  = vote;
  assign bit_stb     = in_frame && at_vote;
  assign bit_val     = vote;
  assign run_restart = (state_q == ST_START);

  assert_hold_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_HOLD) |-> (state_q != ST_START));

  assert_done_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BREAK_BITS  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              addr_filt_en,
  input  logic              brk_reset_en,
  input  logic              clr_rxf,
  input  logic              clr_fe,
  input  logic              clr_brk,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              fe_flag,
  output logic              brk_flag,
  output logic              rst_req
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic              line, vote;
  logic              frame_done, frame_b9, frame_stop;
  logic [DATA_W-1:0] frame_data;
  logic              bit_stb, bit_val, run_restart, brk_hit;

  rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_q), .tick(tick16), .rxd(rxd),
    .line(line), .vote(vote)
  );

  rx_frame_ctl #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_q), .tick(tick16), .line(line), .vote(vote),
    .enable(rx_en), .nine_bit(nine_bit), .brk_hit(brk_hit),
    .frame_done(frame_done), .frame_data(frame_data), .frame_b9(frame_b9),
    .frame_stop(frame_stop), .bit_stb(bit_stb), .bit_val(bit_val),
    .run_restart(run_restart)
  );

  rx_lowrun #(.RUN_LEN(BREAK_BITS)) u_lowrun (
    .clk(clk), .rst_n(rst_q), .bit_stb(bit_stb), .bit_val(bit_val),
    .restart(run_restart), .hit(brk_hit)
  );

  logic              rxf_q, rxf_d, fe_q, fe_d, brk_q, brk_d, rreq_q, rreq_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              b9_q, b9_d, accept, load;

  always_comb begin
    accept = frame_done && !(nine_bit && addr_filt_en && !frame_b9);
    load   = accept && (!rxf_q || clr_rxf);
    rxf_d  = (rxf_q && !clr_rxf) || accept;
    fe_d   = (fe_q && !clr_fe) || (frame_done && !frame_stop);
    brk_d  = (brk_q && !clr_brk) || brk_hit;
    rreq_d = brk_hit && rx_en && brk_reset_en;
    data_d = load ? frame_data : data_q;
    b9_d   = load ? frame_b9 : b9_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rxf_q  <= 1'b0;
      fe_q   <= 1'b0;
      brk_q  <= 1'b0;
      rreq_q <= 1'b0;
      data_q <= '0;
      b9_q   <= 1'b0;
    end else begin
      rxf_q  <= rxf_d;
      fe_q   <= fe_d;
      brk_q  <= brk_d;
      rreq_q <= rreq_d;
      data_q <= data_d;
      b9_q   <= b9_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_bit9  = b9_q;
  assign rx_flag  = rxf_q;
  assign fe_flag  = fe_q;
  assign brk_flag = brk_q;
  assign rst_req  = rreq_q;

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (rxf_q && !clr_rxf) |=> (rxf_q && $stable(data_q) && $stable(b9_q)));

  assert_brk_sticky_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (brk_q && !clr_brk) |=> brk_q);

  assert_fe_sticky_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (fe_q && !clr_fe) |=> fe_q);

  assert_rstreq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_q)
    rreq_q |-> (brk_q && $rose(brk_q)));

  assert_mp_filter_R9: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(rxf_q) && nine_bit && addr_filt_en) |-> b9_q);

endmodule

// File: tb/test_serial_rx_brk.sv
module test_serial_rx_brk;

  localparam int BIT_CLKS = 64;  // tick every 4 clocks, 16 ticks per bit

  logic       clk = 1'b0;
  logic       rst_n, rxd, rx_en, nine_bit, addr_filt_en, brk_reset_en;
  logic       clr_rxf = 1'b0;
  logic       clr_fe, clr_brk;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_flag, fe_flag, brk_flag, rst_req;
  logic [1:0] divcnt = 2'd0;
  logic       tick16;

  always #5 clk = ~clk;
  always @(posedge clk) divcnt <= divcnt + 2'd1;
  assign tick16 = (divcnt == 2'd3);

  serial_rx_brk i_serial_rx_brk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .nine_bit(nine_bit), .addr_filt_en(addr_filt_en), .brk_reset_en(brk_reset_en),
    .clr_rxf(clr_rxf), .clr_fe(clr_fe), .clr_brk(clr_brk),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
    .fe_flag(fe_flag), .brk_flag(brk_flag), .rst_req(rst_req)
  );

  typedef struct packed { logic [7:0] d; logic b9; } exp_t;
  exp_t sb_q[$];
  exp_t mon_e;
  int   n_chk = 0, n_fail = 0, rst_cnt = 0;
  bit   auto_clr = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_req) rst_cnt++;

  // scoreboard monitor: pops an expected item whenever a character is flagged
  always @(negedge clk) begin
    if (clr_rxf) clr_rxf <= 1'b0;
    else if (rx_flag && auto_clr) begin
      if (sb_q.size() == 0) chk(1'b0, "R1 R9 unexpected character", int'(rx_data), -1);
      else begin
        mon_e = sb_q.pop_front();
        chk(rx_data == mon_e.d, "R1 R2 data", int'(rx_data), int'(mon_e.d));
        chk(rx_bit9 == mon_e.b9, "R1 R2 ninth bit", int'(rx_bit9), int'(mon_e.b9));
      end
      clr_rxf <= 1'b1;
    end
  end

  task automatic line_for(input logic v, input int bits);
    rxd = v;
    repeat (bits * BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop, input bit push_it);
    exp_t e;
    line_for(1'b0, 1);
    for (int i = 0; i < 8; i++) line_for(d[i], 1);
    if (nine_bit) line_for(b9, 1);
    e.d  = d;
    e.b9 = nine_bit ? b9 : stop;
    if (push_it) sb_q.push_back(e);
    line_for(stop, 1);
    line_for(1'b1, 2);
  endtask

  task automatic pulse_fe;
    clr_fe = 1'b1; @(negedge clk); clr_fe = 1'b0;
  endtask

  task automatic pulse_brk;
    clr_brk = 1'b1; @(negedge clk); clr_brk = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    exp_t e;
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b1; nine_bit = 1'b0;
    addr_filt_en = 1'b0; brk_reset_en = 1'b0; clr_fe = 1'b0; clr_brk = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(rx_flag == 1'b0, "R12 rx_flag", int'(rx_flag), 0);
    chk(fe_flag == 1'b0, "R12 fe_flag", int'(fe_flag), 0);
    chk(brk_flag == 1'b0, "R12 brk_flag", int'(brk_flag), 0);
    chk(rst_req == 1'b0, "R12 rst_req", int'(rst_req), 0);
    chk(rx_data == 8'h00 && rx_bit9 == 1'b0, "R12 data", int'(rx_data), 0);
    auto_clr = 1'b1;

    // R1 short frames
    send_frame(8'hA5, 1'b0, 1'b1, 1'b1);
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1);
    send_frame(8'hFF, 1'b0, 1'b1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b1, 1'b1);

    // R4 framing error, sticky until cleared
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    chk(fe_flag == 1'b1, "R4 fe set", int'(fe_flag), 1);
    line_for(1'b1, 2);
    chk(fe_flag == 1'b1, "R4 fe sticky", int'(fe_flag), 1);
    pulse_fe();
    chk(fe_flag == 1'b0, "R4 fe cleared", int'(fe_flag), 0);

    // R5 boundary: ten lows then high is not a break
    send_frame(8'h00, 1'b0, 1'b0, 1'b1);
    chk(brk_flag == 1'b0, "R5 ten lows no break", int'(brk_flag), 0);
    chk(fe_flag == 1'b1, "R4 fe on zero frame", int'(fe_flag), 1);
    pulse_fe();

    // R3 short low glitch rejected as noise, then recovery
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    line_for(1'b1, 3);
    chk(rx_flag == 1'b0 && sb_q.size() == 0, "R3 glitch no frame", int'(rx_flag), 0);
    chk(fe_flag == 1'b0, "R3 glitch no fe", int'(fe_flag), 0);
    send_frame(8'hC3, 1'b0, 1'b1, 1'b1);

    // R5 R8 short-mode break with reset request
    brk_reset_en = 1'b1;
    e.d = 8'h00; e.b9 = 1'b0; sb_q.push_back(e);
    line_for(1'b0, 12);
    chk(brk_flag == 1'b1, "R5 break short mode", int'(brk_flag), 1);
    chk(rst_cnt == 1, "R8 reset request pulse", rst_cnt, 1);
    line_for(1'b1, 3);
    chk(brk_flag == 1'b1, "R7 break sticky", int'(brk_flag), 1);
    pulse_brk();
    pulse_fe();
    chk(brk_flag == 1'b0, "R7 break cleared", int'(brk_flag), 0);

    // R2 long frames
    brk_reset_en = 1'b0;
    nine_bit = 1'b1;
    line_for(1'b1, 1);
    send_frame(8'h12, 1'b1, 1'b1, 1'b1);
    send_frame(8'h81, 1'b0, 1'b1, 1'b1);

    // R6 boundary: ten lows with high stop
    send_frame(8'h00, 1'b0, 1'b1, 1'b1);
    chk(brk_flag == 1'b0, "R6 ten lows no break", int'(brk_flag), 0);
    chk(fe_flag == 1'b0, "R6 no fe", int'(fe_flag), 0);

    // R6 R8 R11 long-mode break, reset disabled, line held low
    e.d = 8'h00; e.b9 = 1'b0; sb_q.push_back(e);
    line_for(1'b0, 12);
    chk(brk_flag == 1'b1, "R6 break long mode", int'(brk_flag), 1);
    chk(rst_cnt == 1, "R8 no request when disabled", rst_cnt, 1);
    pulse_fe();
    line_for(1'b0, 8);
    chk(fe_flag == 1'b0, "R11 no fe while held low", int'(fe_flag), 0);
    chk(rx_flag == 1'b0 && sb_q.size() == 0, "R11 no frame while held low", int'(rx_flag), 0);
    line_for(1'b1, 3);
    pulse_brk();
    send_frame(8'h6E, 1'b1, 1'b1, 1'b1);

    // R9 address filter
    addr_filt_en = 1'b1;
    line_for(1'b1, 1);
    send_frame(8'h33, 1'b0, 1'b1, 1'b0);
    chk(rx_flag == 1'b0, "R9 data frame filtered", int'(rx_flag), 0);
    send_frame(8'h77, 1'b1, 1'b1, 1'b1);

    // R10 hold while flag set
    addr_filt_en = 1'b0;
    auto_clr = 1'b0;
    line_for(1'b1, 1);
    send_frame(8'h11, 1'b1, 1'b1, 1'b0);
    send_frame(8'h22, 1'b0, 1'b1, 1'b0);
    chk(rx_flag == 1'b1, "R10 flag held", int'(rx_flag), 1);
    chk(rx_data == 8'h11, "R10 data not overwritten", int'(rx_data), 'h11);
    chk(rx_bit9 == 1'b1, "R10 ninth bit not overwritten", int'(rx_bit9), 1);
    e.d = 8'h11; e.b9 = 1'b1; sb_q.push_back(e);
    auto_clr = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(8'h44, 1'b0, 1'b1, 1'b1);

    line_for(1'b1, 2);
    chk(sb_q.size() == 0, "R1 all characters seen", sb_q.size(), 0);
    finish_run();
  end

endmodule